// File: doc/BRIEF.md
# Accumulator Arithmetic and Shift Unit

This unit is the arithmetic core of a small accumulator machine. It takes an operand from the memory data path and a latched copy of the accumulator. One-hot select lines pick one result: add, subtract, shift left, shift right, or a plain transfer of the memory operand. The chosen result is captured in an output register on the next rising clock edge. That register also holds a copy of the result's top bit as a sign flag.

The adder gets all of its internal carries from a lookahead network in a single evaluation, so no carry ripples from bit to bit. For subtraction the memory operand is inverted and the first carry is forced high, which gives the accumulator minus the memory operand. For addition the first carry comes from a separate input. The same add path therefore increments the program counter: drive the counter value on the accumulator input, drive zero on the memory input, and raise the carry.

Top module: `accu_alu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result` and `sign` become zero on that edge, whatever the operation inputs are.
- R2: With only `op_sel[1]` set (add), `result` after the next rising edge equals `mem_opnd + acc_copy + carry_in` modulo 256; the carry out of the top bit is discarded.
- R3: With only `op_sel[2]` set (subtract), `result` after the next rising edge equals `acc_copy - mem_opnd` modulo 256, and `carry_in` has no effect on it.
- R4: With only `op_sel[3]` set (shift left), `result` after the next rising edge is `mem_opnd` moved up one place with 0 in bit 0.
- R5: With only `op_sel[4]` set (shift right), `result` after the next rising edge is `mem_opnd` moved down one place with bit 7 copied from `mem_opnd[7]`.
- R6: With only `op_sel[0]` set (transfer), `result` after the next rising edge equals `mem_opnd`.
- R7: With no bit of `op_sel` set, `result` becomes zero after the next rising edge. Setting more than one bit is a usage error, and simulation flags it.
- R8: `sign` is updated on the same edge as `result` and always equals bit 7 of the value just captured.
- R9: Adding with `mem_opnd` = 0 and `carry_in` = 1 gives `acc_copy + 1`, so 0xFF wraps to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_opnd | input | 8 | Operand from the memory data path; this is the one that is inverted, shifted or transferred |
| acc_copy | input | 8 | Latched copy of the accumulator |
| carry_in | input | 1 | First carry for the add operation |
| op_sel | input | 5 | One-hot select: bit 0 transfer, bit 1 add, bit 2 subtract, bit 3 shift left, bit 4 shift right |
| result | output | 8 | Registered result |
| sign | output | 1 | Registered bit 7 of the result |

## Verification
Every result passes through exactly one register, so it is due on the first rising edge after the inputs are applied. The bench drives inputs on a falling edge, lets one rising edge capture them, and samples on the following falling edge. Nothing is read in the half cycle where the register changes. The reset value is read on a falling edge while reset is still held, and the sign flag is compared with the same sample as the result it belongs to.

// File: rtl/accu_alu_pkg.sv
// Package accu_alu_pkg
// Holds the bit positions of the one-hot operation select shared by the
// unit, its checker and its users. Assumes one select bit per operation.
package accu_alu_pkg;
    localparam int OP_XFER  = 0;
    localparam int OP_ADD   = 1;
    localparam int OP_SUB   = 2;
    localparam int OP_SHL   = 3;
    localparam int OP_SHR   = 4;
    localparam int NUM_OPS  = 5;
endpackage

// File: rtl/accu_alu_cla.sv
// Module accu_alu_cla
// Lookahead adder: every carry is built directly from the generate and
// propagate terms of the bits below it plus the first carry, so no carry
// depends on another carry. The carry out of the top bit is not produced.
// Assumes WIDTH stays small (the terms grow with the square of WIDTH).
module accu_alu_cla #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] add_a,
    input  logic [WIDTH-1:0] add_b,
    input  logic             first_carry,
    output logic [WIDTH-1:0] add_sum
);
    logic [WIDTH-1:0] gen_t;
    logic [WIDTH-1:0] prop_t;
    logic [WIDTH-1:0] carry_v;

    // Carry into bit pos, flattened as a sum of products of g, p and c0.
    function automatic logic carry_into(input int pos,
                                        input logic [WIDTH-1:0] g,
                                        input logic [WIDTH-1:0] p,
                                        input logic c0);
        logic any_term;
        logic chain;
        chain = c0;
        for (int k = 0; k < pos; k++) chain = chain & p[k];
        any_term = chain;
        for (int j = 0; j < pos; j++) begin
            chain = g[j];
            for (int k = j + 1; k < pos; k++) chain = chain & p[k];
            any_term = any_term | chain;
        end
        return any_term;
    endfunction

    assign gen_t  = add_a & add_b;
    assign prop_t = add_a ^ add_b;

    // One lookahead term per bit position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_carry
        assign carry_v[i] = carry_into(i, gen_t, prop_t, first_carry);
    end

    assign add_sum = prop_t ^ carry_v;
endmodule

// File: rtl/accu_alu_shift.sv
// Module accu_alu_shift
// Single-place shifter. SHIFT_LEFT=1 moves bits up and inserts 0 at the
// bottom; SHIFT_LEFT=0 moves bits down and copies the top bit (arithmetic).
// Assumes WIDTH >= 2.
module accu_alu_shift #(
    parameter int WIDTH      = 8,
    parameter bit SHIFT_LEFT = 1'b1
) (
    input  logic [WIDTH-1:0] sh_in,
    output logic [WIDTH-1:0] sh_out
);
    if (SHIFT_LEFT) begin : g_left
        assign sh_out = {sh_in[WIDTH-2:0], 1'b0};
    end else begin : g_right
        assign sh_out = {sh_in[WIDTH-1], sh_in[WIDTH-1:1]};
    end
endmodule

// File: rtl/accu_alu_omux.sv
// Module accu_alu_omux
// AND-OR result selector. Each candidate is gated by its own select bit
// and the gated words are ORed. Assumes at most one select bit is set;
// with none set the output is zero.
module accu_alu_omux #(
    parameter int WIDTH = 8,
    parameter int NSEL  = 5
) (
    input  logic [NSEL-1:0]            pick,
    input  logic [NSEL-1:0][WIDTH-1:0] cand,
    output logic [WIDTH-1:0]           chosen
);
    // Merge the gated candidates into one word.
    always_comb begin
        chosen = '0;
        for (int i = 0; i < NSEL; i++) begin
            chosen = chosen | (cand[i] & {WIDTH{pick[i]}});
        end
    end
endmodule

// File: rtl/accu_alu.sv
// Module accu_alu
// Accumulator arithmetic unit: add, subtract (acc - mem), shift left,
// arithmetic shift right and transfer, picked by a one-hot select and
// captured in an output register with a sign copy. Assumes the select is
// one-hot or zero and that reset is synchronous and active low.
module accu_alu
    import accu_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   mem_opnd,
    input  logic [WIDTH-1:0]   acc_copy,
    input  logic               carry_in,
    input  logic [NUM_OPS-1:0] op_sel,
    output logic [WIDTH-1:0]   result,
    output logic               sign
);
    logic [WIDTH-1:0]              adder_a;
    logic                          adder_c0;
    logic [WIDTH-1:0]              adder_sum;
    logic [WIDTH-1:0]              shl_word;
    logic [WIDTH-1:0]              shr_word;
    logic [NUM_OPS-1:0][WIDTH-1:0] cand_words;
    logic [WIDTH-1:0]              next_word;

    // Subtract inverts the memory operand and forces the first carry.
    always_comb begin
        adder_a  = op_sel[OP_SUB] ? ~mem_opnd : mem_opnd;
        adder_c0 = op_sel[OP_SUB] ? 1'b1 : carry_in;
    end

    accu_alu_cla #(.WIDTH(WIDTH)) u_cla (
        .add_a       (adder_a),
        .add_b       (acc_copy),
        .first_carry (adder_c0),
        .add_sum     (adder_sum)
    );

    accu_alu_shift #(.WIDTH(WIDTH), .SHIFT_LEFT(1'b1)) u_shl (
        .sh_in  (mem_opnd),
        .sh_out (shl_word)
    );

    accu_alu_shift #(.WIDTH(WIDTH), .SHIFT_LEFT(1'b0)) u_shr (
        .sh_in  (mem_opnd),
        .sh_out (shr_word)
    );

    // Place each operation's word at its select position.
    always_comb begin
        cand_words          = '0;
        cand_words[OP_XFER] = mem_opnd;
        cand_words[OP_ADD]  = adder_sum;
        cand_words[OP_SUB]  = adder_sum;
        cand_words[OP_SHL]  = shl_word;
        cand_words[OP_SHR]  = shr_word;
    end

    accu_alu_omux #(.WIDTH(WIDTH), .NSEL(NUM_OPS)) u_omux (
        .pick   (op_sel),
        .cand   (cand_words),
        .chosen (next_word)
    );

    // Output register: capture the chosen word and its top bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            sign   <= 1'b0;
        end else begin
            result <= next_word;
            sign   <= next_word[WIDTH-1];
        end
    end
endmodule

// File: rtl/accu_alu_checker.sv
// Module accu_alu_checker
// Temporal checks on the unit's ports, attached to every accu_alu by bind.
// Assumes one register stage between inputs and result.
module accu_alu_checker
    import accu_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [WIDTH-1:0]   mem_opnd,
    input logic [WIDTH-1:0]   acc_copy,
    input logic               carry_in,
    input logic [NUM_OPS-1:0] op_sel,
    input logic [WIDTH-1:0]   result,
    input logic               sign
);
    logic [WIDTH-1:0] add_ref;
    logic [WIDTH-1:0] sub_ref;
    logic             single_op;

    assign add_ref   = mem_opnd + acc_copy + {{(WIDTH-1){1'b0}}, carry_in};
    assign sub_ref   = acc_copy - mem_opnd;
    assign single_op = ($countones(op_sel) == 1);

    // R7: at most one select bit
    p_onehot_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_sel));

    // R7: idle select yields zero
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == '0) |=> (result == '0));

    // R6
    p_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (single_op && op_sel[OP_XFER]) |=> (result == $past(mem_opnd)));

    // R2
    p_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (single_op && op_sel[OP_ADD]) |=> (result == $past(add_ref)));

    // R3
    p_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (single_op && op_sel[OP_SUB]) |=> (result == $past(sub_ref)));

    // R4
    p_shl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (single_op && op_sel[OP_SHL]) |=>
        (result[0] == 1'b0 && result[WIDTH-1:1] == $past(mem_opnd[WIDTH-2:0])));

    // R5
    p_shr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (single_op && op_sel[OP_SHR]) |=>
        (result[WIDTH-1] == $past(mem_opnd[WIDTH-1]) &&
         result[WIDTH-2:0] == $past(mem_opnd[WIDTH-1:1])));

    // R8: sign follows a transferred operand's top bit
    p_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (single_op && op_sel[OP_XFER]) |=> (sign == $past(mem_opnd[WIDTH-1])));
endmodule

bind accu_alu accu_alu_checker #(.WIDTH(WIDTH)) u_accu_alu_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_opnd (mem_opnd),
    .acc_copy (acc_copy),
    .carry_in (carry_in),
    .op_sel   (op_sel),
    .result   (result),
    .sign     (sign)
);

// File: tb/accu_alu_bench.sv
`timescale 1ns/1ps
// Directed bench for accu_alu: one task per scenario, each checking itself.
module accu_alu_bench;
    localparam logic [4:0] S_NONE = 5'b00000;
    localparam logic [4:0] S_XFER = 5'b00001;
    localparam logic [4:0] S_ADD  = 5'b00010;
    localparam logic [4:0] S_SUB  = 5'b00100;
    localparam logic [4:0] S_SHL  = 5'b01000;
    localparam logic [4:0] S_SHR  = 5'b10000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_opnd = 8'h00;
    logic [7:0] acc_copy = 8'h00;
    logic       carry_in = 1'b0;
    logic [4:0] op_sel = S_NONE;
    logic [7:0] result;
    logic       sign;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    accu_alu u_accu_alu (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_opnd (mem_opnd),
        .acc_copy (acc_copy),
        .carry_in (carry_in),
        .op_sel   (op_sel),
        .result   (result),
        .sign     (sign)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Drive on a falling edge, sample on the next falling edge.
    task automatic apply(input logic [4:0] s, input logic [7:0] a,
                         input logic [7:0] b, input logic c);
        @(negedge clk);
        op_sel = s; mem_opnd = a; acc_copy = b; carry_in = c;
        @(negedge clk);
        check("R8 sign", {7'd0, sign}, {7'd0, result[7]});
    endtask

    task automatic t_reset;
        @(negedge clk);
        op_sel = S_XFER; mem_opnd = 8'hAA;
        @(negedge clk); @(negedge clk);
        check("R1 reset result", result, 8'h00);
        check("R1 reset sign", {7'd0, sign}, 8'h00);
        op_sel = S_NONE;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_add;
        for (int i = 0; i < 16; i++) begin
            logic [7:0] a = 8'(i * 37 + 5);
            logic [7:0] b = 8'(i * 91 + 3);
            logic c = i[0];
            apply(S_ADD, a, b, c);
            check("R2 add", result, 8'(a + b + c));
        end
        apply(S_ADD, 8'h80, 8'h80, 1'b1);
        check("R2 add wrap", result, 8'h01);
    endtask

    task automatic t_sub;
        apply(S_SUB, 8'h05, 8'h03, 1'b0);
        check("R3 sub neg", result, 8'hFE);
        apply(S_SUB, 8'h05, 8'h03, 1'b1);
        check("R3 sub carry_in ignored", result, 8'hFE);
        apply(S_SUB, 8'h11, 8'h40, 1'b1);
        check("R3 sub", result, 8'h2F);
        apply(S_SUB, 8'h00, 8'h00, 1'b0);
        check("R3 sub zero", result, 8'h00);
    endtask

    task automatic t_shl;
        apply(S_SHL, 8'hC3, 8'h00, 1'b1);
        check("R4 shl", result, 8'h86);
        apply(S_SHL, 8'h41, 8'hFF, 1'b0);
        check("R4 shl into sign", result, 8'h82);
    endtask

    task automatic t_shr;
        apply(S_SHR, 8'h81, 8'h00, 1'b0);
        check("R5 shr negative", result, 8'hC0);
        apply(S_SHR, 8'h7E, 8'hFF, 1'b1);
        check("R5 shr positive", result, 8'h3F);
    endtask

    task automatic t_xfer;
        apply(S_XFER, 8'h9C, 8'h11, 1'b1);
        check("R6 xfer", result, 8'h9C);
        apply(S_XFER, 8'h2D, 8'hFF, 1'b0);
        check("R6 xfer", result, 8'h2D);
    endtask

    task automatic t_idle;
        apply(S_XFER, 8'hFF, 8'h00, 1'b0);
        apply(S_NONE, 8'hFF, 8'hFF, 1'b1);
        check("R7 idle zero", result, 8'h00);
    endtask

    task automatic t_pcinc;
        apply(S_ADD, 8'h00, 8'h1F, 1'b1);
        check("R9 pc inc", result, 8'h20);
        apply(S_ADD, 8'h00, 8'hFF, 1'b1);
        check("R9 pc wrap", result, 8'h00);
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_shl();
        t_shr();
        t_xfer();
        t_idle();
        t_pcinc();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule